// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered clock runs at the intended multiple of a reference clock, and reports the outcome as a loss-of-lock flag. Both clocks reach it as single-cycle strobes in one fast sampling clock domain: `ref_tick` marks each reference cycle, and `rec_tick` marks each recovered-clock cycle. A measurement window spans a fixed number of reference cycles. At the end of each window the number of recovered ticks is compared with the window length times the selected divide ratio, which is the same as comparing the divided recovered clock with the reference at full tick resolution.

Two thresholds, expressed in parts per million, give the flag hysteresis. A locked loop is declared lost only when the absolute deviation goes above the wider threshold. A lost loop is declared locked again only when the deviation falls to the narrower threshold or below. While the loop is unlocked, the block emits a one-cycle retry pulse after a fixed number of unlocked windows, so the loop controller can start a fresh acquisition attempt. A power-down input masks both outputs, discards the window in progress, and restarts detection from the unlocked state.

Top module: `freq_lock_monitor`

## Requirements
- R1: During reset and after its release, `lol` is 1 and `reacq` is 0 (with `pwrdn` low), until a window completes.
- R2: A window closes on the 2^WIN_LOG2-th `ref_tick` counted since reset, since the last close, or since power-down was released. It counts the `rec_tick` strobes within it, including one in the closing cycle. The count is compared with ratio × 2^WIN_LOG2 as an absolute difference, and a zero difference keeps a locked state locked.
- R3: `div_sel` selects the ratio: 2'b00 gives 16, 2'b01 gives 32, and 2'b10 and 2'b11 both give 128.
- R4: If the state is locked and the deviation at a window close exceeds floor(UNLOCK_PPM × ratio × 2^WIN_LOG2 / 10^6), `lol` becomes 1.
- R5: If the state is unlocked and the deviation at a window close is at most floor(LOCK_PPM × ratio × 2^WIN_LOG2 / 10^6), `lol` becomes 0.
- R6: A deviation above the lock threshold and at or below the unlock threshold leaves the state unchanged, in either direction of frequency error.
- R7: The lock state changes only on the clock edge that samples the closing `ref_tick`, or through reset or power-down. At mid-window, `lol` still shows the result of the previous window.
- R8: Each window close that leaves the state unlocked advances a counter. On every REACQ_WIN-th such close, `reacq` pulses high for exactly one cycle, two edges after the closing tick. A close that leaves the state locked clears the counter.
- R9: While `pwrdn` is 1, `lol` and `reacq` are 0 and the window counters are held at zero. After release, `lol` is 1 until a full window measured from the release is within the lock threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock cycle |
| rec_tick | input | 1 | One-cycle strobe per recovered clock cycle |
| div_sel | input | 2 | Divide ratio select (00:16, 01:32, 10/11:128) |
| pwrdn | input | 1 | Power-down; masks outputs and restarts detection |
| lol | output | 1 | Loss-of-lock flag, 1 when unlocked |
| reacq | output | 1 | One-cycle request for a reacquisition attempt |

## Verification
The embedded properties assume that both tick inputs are strobes in the `clk` domain and that windows are thousands of cycles long. Under that assumption, a retry pulse and the next window close can never fall in neighbouring cycles. They also assume `div_sel` holds steady for the whole of a window and that REACQ_WIN is at least 2. The stimulus places every tick on a falling edge and builds each reference period from an exact, known pattern of recovered ticks, with extra or missing ticks placed at fixed slots. It changes `div_sel` and `pwrdn` only between ticks, so every window count and its expected deviation is known exactly.

// File: rtl/flm_pkg.sv
// Shared definitions for the frequency lock detector.
// Assumes ppm thresholds and window sizes keep threshold counts below 2^32.
package flm_pkg;

    // Divide-ratio selection codes seen on div_sel.
    typedef enum logic [1:0] {
        DIV_BY_16   = 2'b00,
        DIV_BY_32   = 2'b01,
        DIV_BY_128  = 2'b10,
        DIV_BY_128B = 2'b11
    } div_sel_e;

    // Converts a ppm tolerance into whole ticks for a window of 2^shift ticks.
    function automatic logic [31:0] ppm_to_counts(input int unsigned ppm,
                                                  input int unsigned shift);
        logic [63:0] full;
        full = (64'(ppm) << shift) / 64'd1000000;
        return full[31:0];
    endfunction

endpackage

// File: rtl/flm_window.sv
// Measurement window: counts reference strobes up to 2^WIN_LOG2 and the
// recovered strobes seen in the same span. It raises close for the cycle of
// the final reference strobe and presents the finished count on meas.
// Assumes both strobes are synchronous to clk; the recovered count saturates.
module flm_window #(
    parameter int unsigned WIN_LOG2 = 16,
    parameter int unsigned CW       = WIN_LOG2 + 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          ref_tick,
    input  logic          rec_tick,
    output logic          close,
    output logic [CW-1:0] meas
);

    localparam logic [WIN_LOG2-1:0] REF_LAST = {WIN_LOG2{1'b1}};
    localparam logic [CW-1:0]       REC_SAT  = {CW{1'b1}};

    logic [WIN_LOG2-1:0] ref_cnt;
    logic [CW-1:0]       rec_cnt;

    // Window end detection and the running count including this cycle's tick.
    always_comb begin
        close = ref_tick && (ref_cnt == REF_LAST) && !clear;
        meas  = (rec_tick && (rec_cnt != REC_SAT)) ? rec_cnt + CW'(1) : rec_cnt;
    end

    // Advance both counters; restart the recovered count when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
        end else begin
            if (ref_tick) begin
                ref_cnt <= ref_cnt + WIN_LOG2'(1);
            end
            rec_cnt <= close ? '0 : meas;
        end
    end

    // R2: a closed window leaves both counters at zero for the next one.
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (ref_cnt == '0) && (rec_cnt == '0));

endmodule

// File: rtl/flm_judge.sv
// Lock judgement: at each window close, compares the measured recovered
// count with ratio * 2^WIN_LOG2. It declares loss above the unlock threshold
// and lock at or below the lock threshold, and otherwise holds its state.
// Assumes div_sel is stable across a window and LOCK_PPM <= UNLOCK_PPM.
module flm_judge
    import flm_pkg::*;
#(
    parameter int unsigned WIN_LOG2   = 16,
    parameter int unsigned CW         = WIN_LOG2 + 9,
    parameter int unsigned LOCK_PPM   = 300,
    parameter int unsigned UNLOCK_PPM = 600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          close,
    input  logic [CW-1:0] meas,
    input  logic [1:0]    div_sel,
    output logic          loss
);

    localparam logic [CW-1:0] EXP_16  = CW'(1) << (WIN_LOG2 + 4);
    localparam logic [CW-1:0] EXP_32  = CW'(1) << (WIN_LOG2 + 5);
    localparam logic [CW-1:0] EXP_128 = CW'(1) << (WIN_LOG2 + 7);
    localparam logic [CW-1:0] LK_16   = CW'(ppm_to_counts(LOCK_PPM,   WIN_LOG2 + 4));
    localparam logic [CW-1:0] LK_32   = CW'(ppm_to_counts(LOCK_PPM,   WIN_LOG2 + 5));
    localparam logic [CW-1:0] LK_128  = CW'(ppm_to_counts(LOCK_PPM,   WIN_LOG2 + 7));
    localparam logic [CW-1:0] UL_16   = CW'(ppm_to_counts(UNLOCK_PPM, WIN_LOG2 + 4));
    localparam logic [CW-1:0] UL_32   = CW'(ppm_to_counts(UNLOCK_PPM, WIN_LOG2 + 5));
    localparam logic [CW-1:0] UL_128  = CW'(ppm_to_counts(UNLOCK_PPM, WIN_LOG2 + 7));

    logic [CW-1:0] exp_cnt;
    logic [CW-1:0] lock_thr;
    logic [CW-1:0] unlock_thr;
    logic [CW-1:0] dev;

    // Pick the expected count and both thresholds for the selected ratio.
    always_comb begin
        case (div_sel_e'(div_sel))
            DIV_BY_16: begin
                exp_cnt    = EXP_16;
                lock_thr   = LK_16;
                unlock_thr = UL_16;
            end
            DIV_BY_32: begin
                exp_cnt    = EXP_32;
                lock_thr   = LK_32;
                unlock_thr = UL_32;
            end
            default: begin
                exp_cnt    = EXP_128;
                lock_thr   = LK_128;
                unlock_thr = UL_128;
            end
        endcase
        dev = (meas > exp_cnt) ? meas - exp_cnt : exp_cnt - meas;
    end

    // Hysteretic state update, evaluated only when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            loss <= 1'b1;
        end else if (close) begin
            if (loss) begin
                loss <= (dev > lock_thr);
            end else begin
                loss <= (dev > unlock_thr);
            end
        end
    end

    // R7: the state holds between window closes.
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!close && !clear) |=> $stable(loss));

    // R9: power-down always returns the detector to the unlocked state.
    p_clear_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> loss);

endmodule

// File: rtl/flm_retry.sv
// Reacquisition pacing: counts window closes that leave the state unlocked
// and raises a one-cycle request on every REACQ_WIN-th one. It acts one
// cycle after the close, when the judged state has settled.
// Assumes REACQ_WIN >= 2 and windows much longer than two cycles.
module flm_retry #(
    parameter int unsigned REACQ_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic close,
    input  logic loss,
    output logic reacq
);

    localparam int unsigned CNTW = $clog2(REACQ_WIN + 1);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(REACQ_WIN - 1);

    logic            close_q;
    logic [CNTW-1:0] miss_cnt;

    // Delay the close strobe, tally unlocked windows, and emit the request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            close_q  <= 1'b0;
            miss_cnt <= '0;
            reacq    <= 1'b0;
        end else begin
            close_q <= close;
            reacq   <= 1'b0;
            if (close_q) begin
                if (!loss) begin
                    miss_cnt <= '0;
                end else if (miss_cnt == CNT_LAST) begin
                    miss_cnt <= '0;
                    reacq    <= 1'b1;
                end else begin
                    miss_cnt <= miss_cnt + CNTW'(1);
                end
            end
        end
    end

    // R8: a request lasts exactly one cycle.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reacq |=> !reacq);

    // R8: requests are only raised while unlocked.
    p_only_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reacq |-> loss);

endmodule

// File: rtl/freq_lock_monitor.sv
// Frequency lock detector top: window counting, hysteretic lock judgement,
// and paced reacquisition requests, with both outputs masked in power-down.
// Assumes ref_tick and rec_tick are clk-synchronous strobes.
module freq_lock_monitor #(
    parameter int unsigned WIN_LOG2   = 16,
    parameter int unsigned LOCK_PPM   = 300,
    parameter int unsigned UNLOCK_PPM = 600,
    parameter int unsigned REACQ_WIN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       rec_tick,
    input  logic [1:0] div_sel,
    input  logic       pwrdn,
    output logic       lol,
    output logic       reacq
);

    localparam int unsigned CW = WIN_LOG2 + 9;

    logic          close;
    logic [CW-1:0] meas;
    logic          loss;
    logic          reacq_raw;

    flm_window #(
        .WIN_LOG2 (WIN_LOG2),
        .CW       (CW)
    ) window_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pwrdn),
        .ref_tick (ref_tick),
        .rec_tick (rec_tick),
        .close    (close),
        .meas     (meas)
    );

    flm_judge #(
        .WIN_LOG2   (WIN_LOG2),
        .CW         (CW),
        .LOCK_PPM   (LOCK_PPM),
        .UNLOCK_PPM (UNLOCK_PPM)
    ) judge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pwrdn),
        .close   (close),
        .meas    (meas),
        .div_sel (div_sel),
        .loss    (loss)
    );

    flm_retry #(
        .REACQ_WIN (REACQ_WIN)
    ) retry_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pwrdn),
        .close (close),
        .loss  (loss),
        .reacq (reacq_raw)
    );

    // Output masking during power-down.
    always_comb begin
        lol   = loss & ~pwrdn;
        reacq = reacq_raw & ~pwrdn;
    end

    // R9: leaving power-down shows the unlocked state at once.
    p_release_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrdn) |-> lol);

endmodule

// File: tb/freq_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module freq_lock_monitor_tb_top;

    localparam int WL  = 8;
    localparam int WIN = 1 << WL;
    localparam int RW  = 2;
    localparam int NROW = 9;

    // Offset in ppm, expected lol after the window, expected reacq pulses.
    localparam int TBL_PPM [NROW] = '{0, 700, 450, 250, 450, -450, -700, -250, 0};
    localparam int TBL_LOL [NROW] = '{0, 1,   1,   0,   0,   0,    1,    0,    0};
    localparam int TBL_RQ  [NROW] = '{0, 0,   1,   0,   0,   0,    0,    0,    0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       rec_tick = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       pwrdn = 1'b0;
    logic       lol;
    logic       reacq;

    int checks = 0;
    int fails = 0;
    int reacq_seen = 0;

    always #2 clk = ~clk;

    freq_lock_monitor #(
        .WIN_LOG2   (WL),
        .LOCK_PPM   (300),
        .UNLOCK_PPM (600),
        .REACQ_WIN  (RW)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .rec_tick (rec_tick),
        .div_sel  (div_sel),
        .pwrdn    (pwrdn),
        .lol      (lol),
        .reacq    (reacq)
    );

    // Tally retry requests as they appear.
    always @(posedge clk) if (reacq) reacq_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference periods of 2*ticks cycles with ticks recovered strobes each;
    // extra > 0 adds a strobe to the first extra periods, extra < 0 drops one.
    task automatic run_periods(input int n, input int ticks, input int extra);
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < 2 * ticks; c++) begin
                @(negedge clk);
                rec_tick = ((c % 2 == 0) && !(extra < 0 && p < -extra && c == 0))
                           || (extra > 0 && p < extra && c == 1);
                ref_tick = (c == 2 * ticks - 1);
            end
        end
        @(negedge clk);
        rec_tick = 1'b0;
        ref_tick = 1'b0;
    endtask

    function automatic int ppm_delta(input int ppm, input int expcnt);
        longint a;
        int d;
        a = (ppm < 0) ? -longint'(ppm) : longint'(ppm);
        d = int'((a * expcnt + 500000) / 1000000);
        return (ppm < 0) ? -d : d;
    endfunction

    task automatic full_window(input int ppm, input int ticks);
        run_periods(WIN, ticks, ppm_delta(ppm, ticks * WIN));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        int prev;
        string tag;

        repeat (4) @(negedge clk);
        check("R1 lol in reset", lol, 1);
        check("R1 reacq in reset", reacq, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 lol after reset", lol, 1);

        // Table walk at ratio 16 through the hysteresis band.
        for (int i = 0; i < NROW; i++) begin
            prev = (i == 0) ? 1 : TBL_LOL[i-1];
            r0 = reacq_seen;
            run_periods(WIN / 2, 16, ppm_delta(TBL_PPM[i], 16 * WIN));
            check("R7 mid-window lol", lol, prev);
            run_periods(WIN / 2, 16, 0);
            repeat (3) @(negedge clk);
            if (TBL_PPM[i] == 0 && prev == 0) tag = "R2 steady lock";
            else if (TBL_LOL[i] != prev) tag = (TBL_LOL[i] != 0) ? "R4 unlock" : "R5 relock";
            else tag = "R6 hold band";
            check(tag, lol, TBL_LOL[i]);
            check("R8 reacq pulses", reacq_seen - r0, TBL_RQ[i]);
        end

        // Power-down mid-window, then restart from a fresh window.
        r0 = reacq_seen;
        full_window(700, 16);
        check("R4 unlock before pwrdn", lol, 1);
        run_periods(WIN / 2, 16, 0);
        check("R7 mid-window before pwrdn", lol, 1);
        @(negedge clk);
        pwrdn = 1'b1;
        @(negedge clk);
        check("R9 lol masked", lol, 0);
        check("R9 reacq masked", reacq, 0);
        repeat (10) @(negedge clk);
        check("R9 lol still masked", lol, 0);
        pwrdn = 1'b0;
        @(negedge clk);
        check("R9 lol after release", lol, 1);
        full_window(0, 16);
        check("R9 lock after fresh window", lol, 0);
        check("R9 no reacq across pwrdn", reacq_seen - r0, 0);

        // Ratio selection.
        div_sel = 2'b01;
        full_window(0, 16);
        check("R3 ratio 32 with x16 input", lol, 1);
        full_window(0, 32);
        check("R3 ratio 32 matched", lol, 0);
        div_sel = 2'b11;
        full_window(0, 32);
        check("R3 code 11 acts as 128", lol, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule